// File: doc/BRIEF.md
# Single-Wire Bus Master Timing Engine

This block produces the bit-level waveforms of a single-wire, open-drain bus on which every bit is framed by the master pulling the line low. A host hands it one command at a time over a valid/ready port. The commands are: a bus reset with a check for a presence answer, writing or reading a single bit, writing or reading a whole byte (least significant bit first), holding a strong pullup for a fixed time, and writing a byte that is followed directly by that strong pullup. The block drives an open-drain pull-low enable and a separate strong-pullup enable. It reads the line back through one input, which is high whenever nothing pulls it low.

All durations are counted in whole microseconds. A prescaler derives the microsecond tick from the `TICKS_PER_US` parameter. Each phase of a transfer (low time, released time, recovery, pullup) has its own microsecond parameter. Command bytes, address selection and integrity checks are built on top of this engine by the host.

Command port rules: `cmd_ready` is high only while the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. While `cmd_ready` is low, `cmd_valid` is ignored and nothing is queued. The host may hold `cmd_valid` high for as long as it needs to and loses nothing by doing so. `done` pulses once at the end of every command.

Top module: `sw_bus_master`

## Requirements
- R1: After reset the line is released (`bus_pull_low`=0), `spu_on`=0, `cmd_ready`=1, `presence`=0 and `rd_data`=0.
- R2: Opcode 0 (bus reset) pulls the line low for RST_LOW_US (480 µs) and then releases it for RST_LISTEN_US (480 µs). The command takes 960 µs in all.
- R3: During a bus reset, `presence` is set to the inverse of the line sampled PRES_US (70 µs) after the release. A slave that pulls low 15–60 µs after the release and holds it for 60–240 µs therefore gives `presence`=1. A silent bus gives 0.
- R4: Opcode 1 with `cmd_data[0]`=1 writes a one: the line is low for W1_LOW_US (6 µs) and then released. The slot lasts SLOT_US (65 µs) and is followed by REC_US (5 µs) of released recovery, 70 µs in total.
- R5: Opcode 1 with `cmd_data[0]`=0 writes a zero: the line is low for W0_LOW_US (60 µs) of the 65 µs slot. The whole command still takes 70 µs.
- R6: Opcode 2 reads one bit. The line is low for RD_LOW_US (6 µs) and the line is sampled at RD_SAMPLE_US (13 µs) after the falling edge, which is before 15 µs. The bit is returned in `rd_data[0]` with the other bits zero.
- R7: Opcode 3 writes `cmd_data` as eight slots and opcode 4 reads eight slots. Both work least significant bit first, so the first bit read lands in `rd_data[0]`. Each byte takes 560 µs.
- R8: Opcode 5 raises `spu_on` for SPU_US and issues no slot. `bus_pull_low` and `spu_on` are never high together.
- R9: Opcode 6 writes `cmd_data` like opcode 3 and then raises `spu_on` for SPU_US. The pullup starts 70 µs after the falling edge of the last slot, which is 5 µs after that slot ends. No slot is issued while it is on.
- R10: `cmd_valid` is ignored while `cmd_ready` is low and causes no extra pulse and no change of duration. `presence` and `rd_data` keep their values through later commands that do not produce them.
- R11: The line is never held low continuously for RST_CAP_US (960 µs) or longer.
- R12: `done` is high for exactly one cycle per command, in the cycle before `cmd_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken when valid is also high |
| cmd_op | input | 3 | Opcode (0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte, 5 pullup, 6 write byte then pullup) |
| cmd_data | input | 8 | Write data (bit 0 for single-bit writes) |
| done | output | 1 | One-cycle end-of-command pulse |
| presence | output | 1 | Result of the last bus reset |
| rd_data | output | 8 | Result of the last read command |
| bus_in | input | 1 | Line level read back |
| bus_pull_low | output | 1 | Open-drain pull-low enable |
| spu_on | output | 1 | Strong pullup enable |

## Verification
The bench models a slave that answers resets and drives zeros in read slots. It measures every low pulse against a queue of expected widths, so a write-1 and write-0 mix-up, a missing or extra slot, or a reversed bit order all show up as a width mismatch or a queue underflow or leftover. Reads with a slave that holds the line for 25 µs catch a sample point taken too late, or the wrong bit placement in `rd_data`. The reset is exercised with and without a responder, which exposes a presence sample taken outside the answer window. A pulse sent while busy, the delay from the last slot to the strong pullup, and the pullup width are timed. These catch an engine that accepts commands mid-transfer, skips the recovery time, or lets slots overlap the pullup.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_WBIT    = 3'd1,
    OP_RBIT    = 3'd2,
    OP_WBYTE   = 3'd3,
    OP_RBYTE   = 3'd4,
    OP_PULLUP  = 3'd5,
    OP_WBYTE_P = 3'd6
  } sbm_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_RLO, S_RHI, S_SLO, S_SHI, S_REC, S_SPU, S_DONE
  } sbm_state_e;
endpackage

// File: rtl/sbm_timer.sv
module sbm_timer #(
  parameter int TICKS_PER_US = 100,
  parameter int US_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  output logic            tick,
  output logic [US_W-1:0] us
);
  localparam int PW = (TICKS_PER_US > 1) ? $clog2(TICKS_PER_US) : 1;
  localparam logic [PW-1:0] PMAX = PW'(TICKS_PER_US - 1);

  logic [PW-1:0] pre;

  assign tick = (pre == PMAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      pre <= '0;
      us  <= '0;
    end else if (tick) begin
      pre <= '0;
      us  <= us + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  // R2
  us_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(us));
endmodule

// File: rtl/sbm_shreg.sv
module sbm_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  input  logic         rx_bit,
  output logic         tx_bit,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx;

  assign tx_bit = tx[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx      <= '0;
      rx_word <= '0;
    end else if (load) begin
      tx      <= din;
      rx_word <= '0;
    end else if (shift) begin
      tx      <= tx >> 1;
      rx_word <= {rx_bit, rx_word[W-1:1]};
    end
  end
endmodule

// File: rtl/sw_bus_master.sv
module sw_bus_master
  import sbm_pkg::*;
#(
  parameter int TICKS_PER_US  = 100,
  parameter int RST_LOW_US    = 480,
  parameter int RST_LISTEN_US = 480,
  parameter int PRES_US       = 70,
  parameter int SLOT_US       = 65,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int RD_LOW_US     = 6,
  parameter int RD_SAMPLE_US  = 13,
  parameter int REC_US        = 5,
  parameter int SPU_US        = 10000,
  parameter int RST_CAP_US    = 960,
  parameter int DW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [2:0]    cmd_op,
  input  logic [DW-1:0] cmd_data,
  output logic          done,
  output logic          presence,
  output logic [DW-1:0] rd_data,
  input  logic          bus_in,
  output logic          bus_pull_low,
  output logic          spu_on
);
  localparam int MAXU = (SPU_US > RST_LOW_US + RST_LISTEN_US) ? SPU_US : RST_LOW_US + RST_LISTEN_US;
  localparam int US_W = $clog2(MAXU + 1);
  localparam int CW   = $clog2(DW + 1);
  localparam int RD_PT = RD_SAMPLE_US - RD_LOW_US;

  if (RST_LOW_US >= RST_CAP_US || RD_SAMPLE_US <= RD_LOW_US || PRES_US >= RST_LISTEN_US)
    begin : g_bad_timing
      $error("sw_bus_master: inconsistent timing parameters");
    end

  sbm_state_e      state;
  sbm_op_e         op_q;
  logic [CW-1:0]   bits_left;
  logic            pres_hit, sample_q;
  logic            tick, tx_bit, phase_end, clr, shift, load;
  logic [US_W-1:0] us;
  logic [US_W-1:0] lim;
  logic [DW-1:0]   rx_word;
  logic            is_wr, is_byte, is_rd;

  assign is_wr   = (op_q == OP_WBIT) || (op_q == OP_WBYTE) || (op_q == OP_WBYTE_P);
  assign is_rd   = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
  assign is_byte = (sbm_op_e'(cmd_op) == OP_WBYTE) || (sbm_op_e'(cmd_op) == OP_RBYTE) ||
                   (sbm_op_e'(cmd_op) == OP_WBYTE_P);

  always_comb begin
    case (state)
      S_RLO:   lim = US_W'(RST_LOW_US);
      S_RHI:   lim = US_W'(RST_LISTEN_US);
      S_SLO:   lim = !is_wr ? US_W'(RD_LOW_US) : tx_bit ? US_W'(W1_LOW_US) : US_W'(W0_LOW_US);
      S_SHI:   lim = !is_wr ? US_W'(SLOT_US - RD_LOW_US) :
                     tx_bit ? US_W'(SLOT_US - W1_LOW_US) : US_W'(SLOT_US - W0_LOW_US);
      S_REC:   lim = US_W'(REC_US);
      S_SPU:   lim = US_W'(SPU_US);
      default: lim = US_W'(1);
    endcase
  end

  assign phase_end    = tick && (us == lim - 1'b1);
  assign clr          = phase_end || (state == S_IDLE) || (state == S_DONE);
  assign load         = (state == S_IDLE) && cmd_valid;
  assign shift        = (state == S_SHI) && phase_end;
  assign cmd_ready    = (state == S_IDLE);
  assign done         = (state == S_DONE);
  assign bus_pull_low = (state == S_RLO) || (state == S_SLO);
  assign spu_on       = (state == S_SPU);

  sbm_timer #(.TICKS_PER_US(TICKS_PER_US), .US_W(US_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(tick), .us(us)
  );

  sbm_shreg #(.W(DW)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(load), .din(cmd_data), .shift(shift),
    .rx_bit(sample_q), .tx_bit(tx_bit), .rx_word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      op_q      <= OP_RESET;
      bits_left <= '0;
      pres_hit  <= 1'b0;
      sample_q  <= 1'b0;
      presence  <= 1'b0;
      rd_data   <= '0;
    end else begin
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q      <= sbm_op_e'(cmd_op);
          bits_left <= is_byte ? CW'(DW) : CW'(1);
          case (sbm_op_e'(cmd_op))
            OP_RESET:  state <= S_RLO;
            OP_PULLUP: state <= S_SPU;
            OP_WBIT, OP_RBIT, OP_WBYTE, OP_RBYTE, OP_WBYTE_P: state <= S_SLO;
            default:   state <= S_DONE;
          endcase
        end
        S_RLO: if (phase_end) begin
          pres_hit <= 1'b0;
          state    <= S_RHI;
        end
        S_RHI: begin
          if (tick && us == US_W'(PRES_US - 1)) pres_hit <= !bus_in;
          if (phase_end) begin
            presence <= pres_hit;
            state    <= S_DONE;
          end
        end
        S_SLO: if (phase_end) state <= S_SHI;
        S_SHI: begin
          if (tick && us == US_W'(RD_PT - 1)) sample_q <= bus_in;
          if (phase_end) begin
            bits_left <= bits_left - 1'b1;
            state     <= S_REC;
          end
        end
        S_REC: if (phase_end) begin
          if (bits_left != '0) state <= S_SLO;
          else if (op_q == OP_WBYTE_P) state <= S_SPU;
          else begin
            if (is_rd) rd_data <= (op_q == OP_RBIT) ? DW'(rx_word[DW-1]) : rx_word;
            state <= S_DONE;
          end
        end
        S_SPU: if (phase_end) state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker state: continuous low-time counter for the cap check.
  int unsigned low_run;
  always_ff @(posedge clk) begin
    if (!rst_n || !bus_pull_low) low_run <= 0;
    else low_run <= low_run + 1;
  end

  // R11
  low_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_pull_low |-> (low_run < RST_CAP_US * TICKS_PER_US));
  // R8
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(spu_on && bus_pull_low));
  // R10
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_pull_low && !spu_on));
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && cmd_ready));
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |=> ($stable(rd_data) && $stable(presence)));
endmodule

// File: tb/sw_bus_master_bench.sv
module sw_bus_master_bench;
  import sbm_pkg::*;
  localparam int TPU = 4;
  localparam int SPU = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cmd_valid = 1'b0, cmd_ready, done, presence, bus_pull_low, spu_on, bus_in;
  logic [2:0] cmd_op = '0;
  logic [7:0] cmd_data = '0, rd_data;
  logic slave_low = 1'b0;
  assign bus_in = ~(bus_pull_low | slave_low);

  sw_bus_master #(.TICKS_PER_US(TPU), .SPU_US(SPU)) u_sw_bus_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .done(done), .presence(presence),
    .rd_data(rd_data), .bus_in(bus_in), .bus_pull_low(bus_pull_low), .spu_on(spu_on)
  );

  int errs = 0, checks = 0, ncyc = 0;
  int exp_q[$];
  bit slv_q[$];
  bit rd_mode = 0, finished = 0;
  int last_fall = 0, spu_delta = 0, spu_width = 0;

  always @(negedge clk) ncyc++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: measure every low pulse and compare with the scoreboard queue.
  initial begin : mon
    int c, w, e;
    forever begin
      @(posedge bus_pull_low);
      last_fall = ncyc;
      c = 0;
      while (bus_pull_low) begin @(negedge clk); c++; end
      w = (c + TPU / 2) / TPU;
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected low pulse (us)", w, 0);
      else begin
        e = exp_q.pop_front();
        chk(w == e, "R2 R4 R5 R6 R7 low pulse width (us)", w, e);
      end
    end
  end

  // Slave: drives zeros during read slots.
  initial begin : slv
    bit b;
    forever begin
      @(posedge bus_pull_low);
      if (rd_mode && slv_q.size() > 0) begin
        b = slv_q.pop_front();
        if (!b) begin
          @(negedge clk) slave_low = 1'b1;
          repeat (25 * TPU) @(negedge clk);
          slave_low = 1'b0;
        end
      end
    end
  end

  // Strong pullup monitor.
  initial begin : spm
    int c;
    forever begin
      @(posedge spu_on);
      spu_delta = ncyc - last_fall;
      c = 0;
      while (spu_on) begin @(negedge clk); c++; end
      spu_width = c;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL R12 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input bit pres,
                       input bit poke, output int dur, output int dones);
    if (pres) fork
      begin
        @(negedge bus_pull_low);
        repeat (30 * TPU) @(negedge clk);
        slave_low = 1'b1;
        repeat (100 * TPU) @(negedge clk);
        slave_low = 1'b0;
      end
    join_none
    @(negedge clk);
    cmd_op = op; cmd_data = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    dur = 0; dones = 0;
    while (!cmd_ready) begin
      dur++;
      if (done) dones++;
      if (poke && dur == 10) begin cmd_valid = 1'b1; cmd_op = OP_RESET; end
      if (poke && dur == 60) cmd_valid = 1'b0;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic push_byte_w(input logic [7:0] d);
    for (int i = 0; i < 8; i++) exp_q.push_back(d[i] ? 6 : 60);
  endtask

  initial begin
    int dur, dn;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(bus_pull_low == 1'b0, "R1 line released", bus_pull_low, 0);
    chk(spu_on == 1'b0, "R1 pullup off", spu_on, 0);
    chk(presence == 1'b0, "R1 presence cleared", presence, 0);
    chk(rd_data == 8'h00, "R1 rd_data cleared", rd_data, 0);

    exp_q.push_back(480);
    issue(OP_RESET, 8'h00, 1, 0, dur, dn);
    chk(dur / TPU == 960, "R2 reset duration (us)", dur / TPU, 960);
    chk(presence == 1'b1, "R3 presence with responder", presence, 1);
    chk(dn == 1, "R12 done pulse count", dn, 1);

    exp_q.push_back(480);
    issue(OP_RESET, 8'h00, 0, 0, dur, dn);
    chk(presence == 1'b0, "R3 presence on silent bus", presence, 0);

    exp_q.push_back(6);
    issue(OP_WBIT, 8'h01, 0, 0, dur, dn);
    chk(dur / TPU == 70, "R4 write-1 duration (us)", dur / TPU, 70);
    exp_q.push_back(60);
    issue(OP_WBIT, 8'h00, 0, 0, dur, dn);
    chk(dur / TPU == 70, "R5 write-0 duration (us)", dur / TPU, 70);

    rd_mode = 1;
    slv_q.push_back(1'b0); exp_q.push_back(6);
    issue(OP_RBIT, 8'h00, 0, 0, dur, dn);
    chk(rd_data == 8'h00, "R6 read bit zero", rd_data, 0);
    slv_q.push_back(1'b1); exp_q.push_back(6);
    issue(OP_RBIT, 8'h00, 0, 0, dur, dn);
    chk(rd_data == 8'h01, "R6 read bit one", rd_data, 1);
    rd_mode = 0;

    push_byte_w(8'hA5);
    issue(OP_WBYTE, 8'hA5, 0, 0, dur, dn);
    chk(dur / TPU == 560, "R7 write byte duration (us)", dur / TPU, 560);

    rd_mode = 1;
    for (int i = 0; i < 8; i++) begin
      slv_q.push_back(((8'h3C >> i) & 8'h01) != 0);
      exp_q.push_back(6);
    end
    issue(OP_RBYTE, 8'h00, 0, 0, dur, dn);
    chk(rd_data == 8'h3C, "R7 read byte LSB first", rd_data, 8'h3C);
    rd_mode = 0;

    exp_q.push_back(6);
    issue(OP_WBIT, 8'h01, 0, 1, dur, dn);
    chk(dur / TPU == 70, "R10 duration with valid while busy (us)", dur / TPU, 70);
    chk(rd_data == 8'h3C, "R10 rd_data held", rd_data, 8'h3C);
    chk(presence == 1'b0, "R10 presence held", presence, 0);

    issue(OP_PULLUP, 8'h00, 0, 0, dur, dn);
    chk(spu_width / TPU == SPU, "R8 pullup width (us)", spu_width / TPU, SPU);
    chk(dur / TPU == SPU, "R8 pullup duration (us)", dur / TPU, SPU);

    push_byte_w(8'h44);
    issue(OP_WBYTE_P, 8'h44, 0, 0, dur, dn);
    chk(spu_delta / TPU == 70, "R9 pullup start after last slot (us)", spu_delta / TPU, 70);
    chk(spu_width / TPU == SPU, "R9 pullup width (us)", spu_width / TPU, SPU);
    chk(dur / TPU == 560 + SPU, "R9 total duration (us)", dur / TPU, 560 + SPU);
    chk(dn == 1, "R12 done pulse count", dn, 1);

    chk(exp_q.size() == 0, "R7 expected pulses left over", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule